// File: doc/BRIEF.md
# Power-Pulsed Acquisition Cycle Sequencer

This block sequences one readout chip through a repeating power-pulsed cycle. A strobe aligned with the bunch train starts each cycle. The sequencer first powers the analog front end for an acquisition window. It then powers the converters, but only those of the channels that fired. Next it powers the readout bus while the data is shipped out. After that it drops every supply and waits in idle for the next strobe. Idle fills most of the cycle, so the average power stays very small.

Each phase opens with a settling interval. In that interval the phase's power enable is already high, but its inputs are not yet looked at. The phase lengths come from a clock rate in kHz and durations in microseconds. The conversion phase ends as soon as every triggered channel reports done, or at the latest when its timer runs out. Each converter is switched off as soon as its own channel reports done. A strobe that arrives while a cycle is still running is dropped and counted.

No data stream passes through this block. All its pins are plain control and status lines, so none of them has a valid/ready handshake and none applies back-pressure.

Top module: `pps_sequencer`

## Requirements
- R1: After reset, `phase` is 0, every power enable is low, and `cycle_done`, `conv_timeout` and `overrun_cnt` are 0.
- R2: The phase codes are 0 idle, 1 acquire, 2 convert and 3 readout. A `cycle_start` seen in idle moves to acquire on the next edge. Acquire lasts ACQ_CYC = CLK_KHZ*ACQ_US/1000 clocks and is followed by convert, then readout, then idle.
- R3: The first SETTLE_CLKS clocks of every phase are settling clocks. In them the phase's enable is high, and `trig_in`, `conv_done` and `ro_complete` have no effect.
- R4: A trigger is latched for channel i when `trig_in[i]` is high during a post-settling acquire clock. All latched triggers and done marks are cleared when `cycle_start` is accepted.
- R5: `adc_pwr_en[i]` is high in convert only while channel i holds a latched trigger and has not yet reported `conv_done[i]` after settling. It falls on the clock after that report.
- R6: Convert ends after the first post-settling clock in which every triggered channel is done, counting the done flags of that same clock. With no triggers at all, it ends after its first post-settling clock.
- R7: Convert is forced to end after CONV_CYC clocks. If any triggered channel is still not done at that point, `conv_timeout` is set, and it stays set until the next accepted `cycle_start`. A channel that finishes on the last clock does not set it.
- R8: Readout ends after a post-settling clock with `ro_complete` high, or otherwise after RDO_CYC clocks.
- R9: `cycle_done` is high for exactly the first idle clock after readout.
- R10: A `cycle_start` outside idle does not change the phase. It increments `overrun_cnt`, which holds at its all-ones value instead of wrapping.
- R11: In idle, `fe_pwr_en`, `ro_pwr_en` and every `adc_pwr_en` bit are low. `fe_pwr_en` is high only in acquire and `ro_pwr_en` only in readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | Bunch-train aligned start strobe |
| trig_in | input | NCH | Per-channel trigger flags |
| conv_done | input | NCH | Per-channel conversion finished flags |
| ro_complete | input | 1 | Readout finished flag |
| fe_pwr_en | output | 1 | Analog front-end power enable |
| adc_pwr_en | output | NCH | Per-channel converter power enables |
| ro_pwr_en | output | 1 | Readout bus power enable |
| phase | output | 2 | Current phase code |
| cycle_done | output | 1 | One-clock end-of-cycle pulse |
| conv_timeout | output | 1 | Conversion timer expired with channels pending |
| overrun_cnt | output | OVR_W | Saturating count of ignored strobes |

## Verification
Two pairs of events can fall in the same clock.

The first pair is the last converter's done flag and the expiry of the convert timer. The bench sends the done flag on the final convert clock. It then expects readout on the next clock with `conv_timeout` still low.

The second pair is the end of readout and a new start strobe. The bench raises `ro_complete` and `cycle_start` together. It expects idle with a `cycle_done` pulse, no new acquire, and an overrun count one higher.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2,
    PH_READ = 2'd3
  } phase_e;
endpackage

// File: rtl/pps_phase_fsm.sv
module pps_phase_fsm
  import pps_pkg::*;
#(
  parameter int TW       = 10,
  parameter int ACQ_CYC  = 1000,
  parameter int CONV_CYC = 500,
  parameter int RDO_CYC  = 500,
  parameter int SETTLE   = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   all_done,
  input  logic   ro_complete,
  output phase_e phase,
  output logic   work,
  output logic   accept,
  output logic   timeout_evt,
  output logic   cycle_end
);
  localparam logic [TW-1:0] ACQ_LAST  = TW'(ACQ_CYC - 1);
  localparam logic [TW-1:0] CONV_LAST = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] RDO_LAST  = TW'(RDO_CYC - 1);
  localparam logic [TW-1:0] SET_LIM   = TW'(SETTLE);

  phase_e        ph_q, ph_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          last;

  assign work  = (tmr_q >= SET_LIM);
  assign phase = ph_q;

  always_comb begin
    unique case (ph_q)
      PH_ACQ:  last = (tmr_q == ACQ_LAST);
      PH_CONV: last = (tmr_q == CONV_LAST);
      PH_READ: last = (tmr_q == RDO_LAST);
      default: last = 1'b0;
    endcase
  end

  always_comb begin
    ph_d        = ph_q;
    tmr_d       = tmr_q + 1'b1;
    accept      = 1'b0;
    timeout_evt = 1'b0;
    cycle_end   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        tmr_d = '0;
        if (start) begin
          ph_d   = PH_ACQ;
          accept = 1'b1;
        end
      end
      PH_ACQ: if (last) begin
        ph_d  = PH_CONV;
        tmr_d = '0;
      end
      PH_CONV: if ((work && all_done) || last) begin
        ph_d        = PH_READ;
        tmr_d       = '0;
        timeout_evt = !(work && all_done);
      end
      PH_READ: if ((work && ro_complete) || last) begin
        ph_d      = PH_IDLE;
        tmr_d     = '0;
        cycle_end = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      tmr_q <= '0;
    end else begin
      ph_q  <= ph_d;
      tmr_q <= tmr_d;
    end
  end

  // R2: acquire only advances to convert
  a_r2_acq_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACQ) |=> (ph_q == PH_ACQ || ph_q == PH_CONV));
  // R2: idle is left only through an accepted strobe
  a_r2_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !start) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/pps_chan_bank.sv
module pps_chan_bank #(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           trig_win,
  input  logic           done_win,
  input  logic           conv_on,
  input  logic [NCH-1:0] trig_in,
  input  logic [NCH-1:0] conv_done,
  output logic [NCH-1:0] adc_en,
  output logic           all_done
);
  logic [NCH-1:0] trig_q, done_q, settled;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
      end else if (clear) begin
        trig_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
      end else begin
        if (trig_win && trig_in[i]) trig_q[i] <= 1'b1;
        if (done_win && conv_done[i]) done_q[i] <= 1'b1;
      end
    end
    assign settled[i] = !trig_q[i] || done_q[i] || (done_win && conv_done[i]);
    assign adc_en[i]  = conv_on && trig_q[i] && !done_q[i];
  end

  assign all_done = &settled;

  // R5: a converter that was off in convert never turns back on within the phase
  a_r5_no_repower: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_on && !clear && adc_en == '0) |=> (adc_en == '0));
endmodule

// File: rtl/pps_overrun_ctr.sv
module pps_overrun_ctr #(
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [OVR_W-1:0] cnt
);
  logic [OVR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (hit && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R10: the count steps by one per ignored strobe until full
  a_r10_overrun_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R10: a full counter stays full
  a_r10_overrun_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_q) |=> (&cnt_q));
endmodule

// File: rtl/pps_sequencer.sv
module pps_sequencer
  import pps_pkg::*;
#(
  parameter int NCH         = 64,
  parameter int CLK_KHZ     = 1000,
  parameter int ACQ_US      = 1000,
  parameter int CONV_US     = 500,
  parameter int RDO_US      = 500,
  parameter int SETTLE_CLKS = 4,
  parameter int OVR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_start,
  input  logic [NCH-1:0]   trig_in,
  input  logic [NCH-1:0]   conv_done,
  input  logic             ro_complete,
  output logic             fe_pwr_en,
  output logic [NCH-1:0]   adc_pwr_en,
  output logic             ro_pwr_en,
  output logic [1:0]       phase,
  output logic             cycle_done,
  output logic             conv_timeout,
  output logic [OVR_W-1:0] overrun_cnt
);
  localparam int ACQ_CYC  = CLK_KHZ * ACQ_US / 1000;
  localparam int CONV_CYC = CLK_KHZ * CONV_US / 1000;
  localparam int RDO_CYC  = CLK_KHZ * RDO_US / 1000;
  localparam int MAX_A    = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int MAX_CYC  = (MAX_A > RDO_CYC) ? MAX_A : RDO_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);

  phase_e ph;
  logic   work, accept, timeout_evt, cycle_end, all_done;
  logic   timeout_q, cycle_done_q;

  pps_phase_fsm #(
    .TW(TW), .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC),
    .RDO_CYC(RDO_CYC), .SETTLE(SETTLE_CLKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(cycle_start), .all_done(all_done),
    .ro_complete(ro_complete), .phase(ph), .work(work), .accept(accept),
    .timeout_evt(timeout_evt), .cycle_end(cycle_end)
  );

  pps_chan_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .trig_win(ph == PH_ACQ && work),
    .done_win(ph == PH_CONV && work),
    .conv_on(ph == PH_CONV),
    .trig_in(trig_in), .conv_done(conv_done),
    .adc_en(adc_pwr_en), .all_done(all_done)
  );

  pps_overrun_ctr #(.OVR_W(OVR_W)) u_ovr (
    .clk(clk), .rst_n(rst_n),
    .hit(cycle_start && ph != PH_IDLE),
    .cnt(overrun_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q    <= 1'b0;
      cycle_done_q <= 1'b0;
    end else begin
      cycle_done_q <= cycle_end;
      if (accept)           timeout_q <= 1'b0;
      else if (timeout_evt) timeout_q <= 1'b1;
    end
  end

  assign fe_pwr_en    = (ph == PH_ACQ);
  assign ro_pwr_en    = (ph == PH_READ);
  assign phase        = ph;
  assign cycle_done   = cycle_done_q;
  assign conv_timeout = timeout_q;

  // R11: idle keeps every supply off
  a_r11_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |-> (!fe_pwr_en && !ro_pwr_en && adc_pwr_en == '0));
  // R11: at most one supply group is on at a time
  a_r11_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fe_pwr_en, ro_pwr_en, |adc_pwr_en}));
  // R3: converter enables do not move during convert settling
  a_r3_conv_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_CONV && !work) |=> $stable(adc_pwr_en));
  // R9: the end pulse lasts one clock and lands in idle
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> (phase == 2'd0 && $past(phase) == 2'd3));
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);
endmodule

// File: tb/pps_sequencer_tb.sv
module pps_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int SETTLE     = 2;
  localparam int CONV_CYC   = 10;

  // {trig[3:0], done[3:0], ro}
  localparam logic [8:0] VEC [6] = '{
    {4'b1010, 4'b1010, 1'b1},
    {4'b1111, 4'b0011, 1'b0},
    {4'b0000, 4'b0000, 1'b1},
    {4'b0001, 4'b0001, 1'b0},
    {4'b0110, 4'b1110, 1'b1},
    {4'b1111, 4'b1111, 1'b1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cycle_start = 1'b0;
  logic [NCH-1:0] trig_in = '0;
  logic [NCH-1:0] conv_done = '0;
  logic           ro_complete = 1'b0;
  logic           fe_pwr_en, ro_pwr_en, cycle_done, conv_timeout;
  logic [NCH-1:0] adc_pwr_en;
  logic [1:0]     phase;
  logic [1:0]     overrun_cnt;
  int             n_run = 0;
  int             n_fail = 0;
  bit             ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_sequencer #(
    .NCH(NCH), .CLK_KHZ(1000), .ACQ_US(8), .CONV_US(CONV_CYC),
    .RDO_US(6), .SETTLE_CLKS(SETTLE), .OVR_W(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .trig_in(trig_in),
    .conv_done(conv_done), .ro_complete(ro_complete), .fe_pwr_en(fe_pwr_en),
    .adc_pwr_en(adc_pwr_en), .ro_pwr_en(ro_pwr_en), .phase(phase),
    .cycle_done(cycle_done), .conv_timeout(conv_timeout),
    .overrun_cnt(overrun_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_phase(input logic [1:0] p);
    for (int k = 0; k < 100 && phase != p; k++) @(negedge clk);
    chk(phase == p, "R2 phase reached", phase, p);
  endtask

  task automatic start_cycle();
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
  endtask

  task automatic run_vec(input logic [3:0] tr, input logic [3:0] dn, input bit ro);
    logic [3:0] pend;
    pend = tr & ~dn;
    start_cycle();
    chk(phase == 2'd1 && fe_pwr_en, "R2 acquire entered", phase, 1);
    repeat (SETTLE) @(negedge clk);
    trig_in = tr;
    @(negedge clk);
    trig_in = '0;
    wait_phase(2'd2);
    chk(adc_pwr_en == tr, "R4 R5 converters of triggered channels", adc_pwr_en, tr);
    repeat (SETTLE) @(negedge clk);
    conv_done = dn;
    @(negedge clk);
    conv_done = '0;
    if (pend == '0)
      chk(phase == 2'd3, "R6 early end of convert", phase, 3);
    else
      chk(phase == 2'd2 && adc_pwr_en == pend, "R5 done channels powered off",
          adc_pwr_en, pend);
    wait_phase(2'd3);
    chk(conv_timeout == (pend != '0), "R7 timeout flag", conv_timeout, pend != '0);
    chk(ro_pwr_en && !fe_pwr_en && adc_pwr_en == '0, "R11 readout power only",
        {ro_pwr_en, fe_pwr_en, adc_pwr_en}, 6'b100000);
    repeat (SETTLE) @(negedge clk);
    ro_complete = ro;
    @(negedge clk);
    ro_complete = 1'b0;
    if (ro) chk(phase == 2'd0, "R8 readout ends on complete", phase, 0);
    else begin
      chk(phase == 2'd3, "R8 readout held without complete", phase, 3);
      wait_phase(2'd0);
    end
    chk(cycle_done == 1'b1, "R9 cycle_done pulse", cycle_done, 1);
    @(negedge clk);
    chk(cycle_done == 1'b0 && !fe_pwr_en && !ro_pwr_en && adc_pwr_en == '0,
        "R9 R11 idle after pulse", {cycle_done, fe_pwr_en, ro_pwr_en}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!ended) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phase == 2'd0 && !fe_pwr_en && !ro_pwr_en && adc_pwr_en == '0 &&
        !cycle_done && !conv_timeout && overrun_cnt == 0, "R1 reset state",
        {phase, fe_pwr_en, ro_pwr_en, cycle_done, conv_timeout}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phase == 2'd0, "R1 idle after reset", phase, 0);

    for (int v = 0; v < 6; v++) run_vec(VEC[v][8:5], VEC[v][4:1], VEC[v][0]);

    // R3: trigger during acquire settling is ignored
    start_cycle();
    trig_in = 4'b1111;
    @(negedge clk);
    trig_in = '0;
    wait_phase(2'd2);
    chk(adc_pwr_en == '0, "R3 settling trigger ignored", adc_pwr_en, 0);
    wait_phase(2'd0);
    @(negedge clk);

    // R7: last done on the final convert clock gives no timeout
    start_cycle();
    repeat (SETTLE) @(negedge clk);
    trig_in = 4'b0001;
    @(negedge clk);
    trig_in = '0;
    wait_phase(2'd2);
    repeat (CONV_CYC - 1) @(negedge clk);
    chk(phase == 2'd2 && adc_pwr_en == 4'b0001, "R7 still converting on last clock",
        adc_pwr_en, 1);
    conv_done = 4'b0001;
    @(negedge clk);
    conv_done = '0;
    chk(phase == 2'd3 && !conv_timeout, "R7 done on expiry clock sets no timeout",
        conv_timeout, 0);
    // R10: strobe together with readout completion is ignored and counted
    repeat (SETTLE) @(negedge clk);
    ro_complete = 1'b1;
    cycle_start = 1'b1;
    @(negedge clk);
    ro_complete = 1'b0;
    cycle_start = 1'b0;
    chk(phase == 2'd0 && cycle_done, "R10 R9 end wins over strobe", phase, 0);
    chk(overrun_cnt == 2'd1, "R10 overrun counted", overrun_cnt, 1);
    @(negedge clk);
    chk(phase == 2'd0, "R10 ignored strobe starts no cycle", phase, 0);

    // R10: strobes during acquire saturate the counter
    start_cycle();
    for (int k = 0; k < 4; k++) begin
      cycle_start = 1'b1;
      @(negedge clk);
      cycle_start = 1'b0;
    end
    chk(overrun_cnt == 2'd3, "R10 overrun saturates", overrun_cnt, 3);
    chk(phase == 2'd1, "R10 phase unchanged by strobes", phase, 1);
    wait_phase(2'd0);

    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule